// File: doc/BRIEF.md
# Video Line Capture Sequencer

This block chooses which lines of an interlaced video field are stored in a line FIFO. The FIFO has no address input; it only has pointer-reset strobes. The sequencer receives the separated vertical and horizontal sync pulses. These pulses arrive asynchronously to the pixel clock. The pixel clock is the same clock that drives the converter and the FIFO write port, so each enabled clock stores exactly one sample.

A vertical sync edge starts a field. The sequencer resets the FIFO write pointer and clears its line count. Each horizontal sync edge advances the count. Lines are captured only inside a window that has three parameters: a first line, a line spacing and a number of lines. On each captured line, the write strobe opens after a blanking delay and stays open for a fixed number of pixels.

After the last line of the window, the read pointer is reset and a ready flag is raised for the host. The flag holds until the host acknowledges it, or until the next field starts.

The controller is a state machine with these states:
- IDLE waits for a field.
- WPRST is a single cycle with the write-pointer reset active.
- SKIP counts lines until the next selected one.
- BLANK waits out the blanking delay.
- WRITE holds the write strobe open.
- RDRST is a single cycle with the read-pointer reset active.
- READY holds the flag.

The transitions are:
- A vertical sync edge moves any state to WPRST.
- WPRST always moves to SKIP.
- SKIP moves to BLANK on the horizontal edge that begins a selected line.
- BLANK moves to WRITE after BLANK_CLKS cycles.
- WRITE moves back to SKIP after PIXELS cycles, or to RDRST when that line was the last of the window.
- RDRST always moves to READY.
- READY moves to IDLE on an acknowledge.

Top module: `vline_capture_seq`

## Requirements
- R1: While reset is asserted, and directly after it, wr_en, wr_ptr_rst, rd_ptr_rst and frame_ready are all low.
- R2: Both sync inputs pass through a two-flop synchroniser and act only on a low-to-high transition. A rise that is driven just after clock edge k has its first effect on the outputs in the cycle after edge k+3. A sync input held high does not retrigger.
- R3: A vertical sync rise produces a wr_ptr_rst pulse exactly one cycle wide and clears the line count.
- R4: Each horizontal sync rise after the vertical sync advances the line count by one. The n-th such rise begins line n.
- R5: Only lines FIRST_LINE + j*LINE_STEP, for j from 0 to CAP_LINES-1, are captured. No other line ever shows wr_en.
- R6: On a captured line, wr_en goes high BLANK_CLKS cycles after the state machine sees the line edge. It stays high for exactly PIXELS consecutive cycles.
- R7: In the cycle after the last window line's write closes, rd_ptr_rst pulses for one cycle. In the cycle after that, frame_ready rises.
- R8: frame_ready holds until ack_in is sampled high, and it is low in the following cycle. ack_in has no effect while frame_ready is low.
- R9: A vertical sync rise while frame_ready is high (with no acknowledge) drops frame_ready together with the wr_ptr_rst pulse and restarts capture.
- R10: At most one of wr_en, wr_ptr_rst, rd_ptr_rst and frame_ready is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock shared with the converter and the FIFO |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync_in | input | 1 | Separated vertical sync, asynchronous |
| hsync_in | input | 1 | Separated horizontal sync, asynchronous |
| ack_in | input | 1 | Host acknowledge that clears frame_ready |
| wr_en | output | 1 | FIFO write strobe, high while pixels are stored |
| wr_ptr_rst | output | 1 | FIFO write-pointer reset pulse |
| rd_ptr_rst | output | 1 | FIFO read-pointer reset pulse |
| frame_ready | output | 1 | Frame stored, waiting for the host |

## Verification
A line counter that is off by one shifts the whole write window by a full line period, so the error shows at wr_en one horizontal period after the sync edge. A wrong pixel or blanking count moves the rising or falling wr_en edge within the line, and the cycle-exact comparison catches it on the first captured line. A captured-line counter that is wrong shows as rd_ptr_rst and frame_ready arriving a line-spacing early or late, or not at all. A stuck READY state shows as a frame_ready that survives an acknowledge or a new field within three cycles.

// File: rtl/vcs_pkg.sv
package vcs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WPRST,
        ST_SKIP,
        ST_BLANK,
        ST_WRITE,
        ST_RDRST,
        ST_READY
    } vcs_state_e;
endpackage

// File: rtl/vcs_sync_edge.sv
module vcs_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], async_in};
    end

    // synchronised level is sh[STAGES-1]; sh[STAGES] is its previous value
    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/vcs_line_track.sv
module vcs_line_track #(
    parameter int LINE_W     = 10,
    parameter int FIRST_LINE = 3,
    parameter int LINE_STEP  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    input  logic bump,
    output logic line_hit
);
    localparam logic [LINE_W-1:0] FIRST_V = LINE_W'(FIRST_LINE);
    localparam logic [LINE_W-1:0] STEP_V  = LINE_W'(LINE_STEP);

    logic [LINE_W-1:0] line_cnt;
    logic [LINE_W-1:0] next_sel;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_cnt <= '0;
            next_sel <= FIRST_V;
        end else if (clear) begin
            line_cnt <= '0;
            next_sel <= FIRST_V;
        end else begin
            if (advance) line_cnt <= line_cnt + 1'b1;
            if (bump)    next_sel <= next_sel + STEP_V;
        end
    end

    // the edge that starts line (line_cnt+1) matches the next selected line
    assign line_hit = advance && ((line_cnt + 1'b1) == next_sel);
endmodule

// File: rtl/vline_capture_seq.sv
module vline_capture_seq
    import vcs_pkg::*;
#(
    parameter int FIRST_LINE  = 3,
    parameter int CAP_LINES   = 4,
    parameter int LINE_STEP   = 2,
    parameter int BLANK_CLKS  = 5,
    parameter int PIXELS      = 16,
    parameter int LINE_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vsync_in,
    input  logic hsync_in,
    input  logic ack_in,
    output logic wr_en,
    output logic wr_ptr_rst,
    output logic rd_ptr_rst,
    output logic frame_ready
);
    localparam int PIX_MAX = (BLANK_CLKS > PIXELS) ? BLANK_CLKS : PIXELS;
    localparam int PIX_W   = $clog2(PIX_MAX + 1);
    localparam int CAP_W   = $clog2(CAP_LINES + 1);
    localparam logic [PIX_W-1:0] BLANK_LAST = PIX_W'(BLANK_CLKS - 1);
    localparam logic [PIX_W-1:0] PIX_LAST   = PIX_W'(PIXELS - 1);
    localparam logic [CAP_W-1:0] CAP_LAST   = CAP_W'(CAP_LINES - 1);

    vcs_state_e state, nxt;
    logic [PIX_W-1:0] pix_cnt;
    logic [CAP_W-1:0] cap_cnt;
    logic [1:0]       sync_raw, sync_rise;
    logic             v_rise, h_rise, line_hit, take;

    assign sync_raw = {hsync_in, vsync_in};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        vcs_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (sync_raw[g]),
            .rise     (sync_rise[g])
        );
    end

    assign v_rise = sync_rise[0];
    assign h_rise = sync_rise[1];

    vcs_line_track #(
        .LINE_W     (LINE_W),
        .FIRST_LINE (FIRST_LINE),
        .LINE_STEP  (LINE_STEP)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (v_rise),
        .advance  (h_rise),
        .bump     (take),
        .line_hit (line_hit)
    );

    // next state
    always_comb begin
        nxt  = state;
        take = 1'b0;
        if (v_rise) begin
            nxt = ST_WPRST;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_IDLE;
                ST_WPRST: nxt = ST_SKIP;
                ST_SKIP: begin
                    if (line_hit) begin
                        nxt  = ST_BLANK;
                        take = 1'b1;
                    end
                end
                ST_BLANK: if (pix_cnt == BLANK_LAST) nxt = ST_WRITE;
                ST_WRITE: begin
                    if (pix_cnt == PIX_LAST)
                        nxt = (cap_cnt == CAP_LAST) ? ST_RDRST : ST_SKIP;
                end
                ST_RDRST: nxt = ST_READY;
                ST_READY: if (ack_in) nxt = ST_IDLE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // pixel and captured-line counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_cnt <= '0;
            cap_cnt <= '0;
        end else begin
            if (nxt != state)
                pix_cnt <= '0;
            else if (state == ST_BLANK || state == ST_WRITE)
                pix_cnt <= pix_cnt + 1'b1;

            if (state == ST_WPRST)
                cap_cnt <= '0;
            else if (state == ST_WRITE && nxt != ST_WRITE)
                cap_cnt <= cap_cnt + 1'b1;
        end
    end

    // outputs
    always_comb begin
        wr_en       = 1'b0;
        wr_ptr_rst  = 1'b0;
        rd_ptr_rst  = 1'b0;
        frame_ready = 1'b0;
        unique case (state)
            ST_WPRST: wr_ptr_rst  = 1'b1;
            ST_WRITE: wr_en       = 1'b1;
            ST_RDRST: rd_ptr_rst  = 1'b1;
            ST_READY: frame_ready = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/vcs_chk.sv
module vcs_chk #(
    parameter int PIXELS = 16
) (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic wr_ptr_rst,
    input logic rd_ptr_rst,
    input logic frame_ready,
    input logic ack_in,
    input logic v_rise
);
    logic [15:0] run;

    always_ff @(posedge clk) begin
        if (!rst_n)     run <= '0;
        else if (wr_en) run <= (run == 16'hFFFF) ? run : run + 1'b1;
        else            run <= '0;
    end

    // R10
    strobes_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, wr_ptr_rst, rd_ptr_rst, frame_ready}));

    // R3
    wprst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr_rst |=> !wr_ptr_rst);

    // R7
    rrst_then_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ptr_rst |=> (frame_ready || wr_ptr_rst));

    // R8
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ready && !ack_in && !v_rise) |=> frame_ready);

    // R8
    ready_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ready && ack_in) |=> !frame_ready);

    // R9
    vsync_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_rise |=> (wr_ptr_rst && !frame_ready && !wr_en));

    // R6
    we_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(wr_en) && !wr_ptr_rst) |-> (run == 16'(PIXELS)));

    // R6
    we_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run <= 16'(PIXELS));
endmodule

bind vline_capture_seq vcs_chk #(.PIXELS(PIXELS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_ptr_rst  (wr_ptr_rst),
    .rd_ptr_rst  (rd_ptr_rst),
    .frame_ready (frame_ready),
    .ack_in      (ack_in),
    .v_rise      (v_rise)
);

// File: tb/vline_capture_seq_bench.sv
`timescale 1ns/1ps
module vline_capture_seq_bench;
    localparam int F  = 3;
    localparam int N  = 4;
    localparam int S  = 2;
    localparam int B  = 5;
    localparam int PX = 16;
    localparam int H0 = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vsync_in = 1'b0, hsync_in = 1'b0, ack_in = 1'b0;
    logic wr_en, wr_ptr_rst, rd_ptr_rst, frame_ready;

    int checks = 0;
    int errors = 0;
    bit prev_ready = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    vline_capture_seq #(
        .FIRST_LINE(F), .CAP_LINES(N), .LINE_STEP(S),
        .BLANK_CLKS(B), .PIXELS(PX)
    ) u_vline_capture_seq (
        .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .hsync_in(hsync_in),
        .ack_in(ack_in), .wr_en(wr_en), .wr_ptr_rst(wr_ptr_rst),
        .rd_ptr_rst(rd_ptr_rst), .frame_ready(frame_ready)
    );

    function automatic bit line_sel(int i);
        return (i >= F) && (((i - F) % S) == 0) && (((i - F) / S) < N);
    endfunction

    task automatic check1(string tag, logic act, logic exp, int t);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0d actual=%0b expected=%0b", tag, t, act, exp);
        end
    endtask

    task automatic run_frame(int nl, int lp, int hw, int vw, bit do_ack);
        int  llast    = F + (N - 1) * S;
        bit  complete = (nl >= llast);
        int  rrst_t   = H0 + (llast - 1) * lp + 3 + B + PX;
        int  a_t;
        int  t_end;
        a_t   = complete ? rrst_t + 1 + int'($urandom_range(0, 8))
                         : H0 + int'($urandom_range(0, nl * lp));
        t_end = ((H0 + nl * lp) > a_t ? (H0 + nl * lp) : a_t) + 12;
        for (int t = 0; t < t_end; t++) begin
            int  li   = (t >= H0) ? (t - H0) / lp + 1 : 0;
            int  offs = (t >= H0) ? (t - H0) % lp : 0;
            bit  e_we, e_wr, e_rr, e_rdy;
            @(negedge clk);
            e_wr  = (t == 3);
            e_we  = (li >= 1) && (li <= nl) && line_sel(li)
                    && (offs >= 3 + B) && (offs < 3 + B + PX);
            e_rr  = complete && (t == rrst_t);
            e_rdy = (prev_ready && t < 3) ||
                    (complete && t > rrst_t && (!do_ack || t <= a_t));
            check1((t < 3) ? "R2 wr_ptr_rst" : "R3 wr_ptr_rst", wr_ptr_rst, e_wr, t);
            if (li >= 1 && li <= nl && line_sel(li))
                check1((li == F) ? "R4 wr_en" : "R6 wr_en", wr_en, e_we, t);
            else
                check1("R5 wr_en", wr_en, e_we, t);
            check1("R7 rd_ptr_rst", rd_ptr_rst, e_rr, t);
            check1((prev_ready && t <= 3) ? "R9 frame_ready" : "R8 frame_ready",
                   frame_ready, e_rdy, t);
            checks++;
            if ($countones({wr_en, wr_ptr_rst, rd_ptr_rst, frame_ready}) > 1) begin
                errors++;
                $display("FAIL R10 t=%0d actual=%b expected=onehot0", t,
                         {wr_en, wr_ptr_rst, rd_ptr_rst, frame_ready});
            end
            vsync_in = (t < vw);
            hsync_in = (t >= H0) && (li <= nl) && (offs < hw);
            ack_in   = do_ack && (t == a_t);
        end
        prev_ready = complete && !do_ack;
    endtask

    initial begin
        process::self().srandom(32'd4711);
        repeat (4) begin
            @(negedge clk);
            check1("R1 reset", wr_en | wr_ptr_rst | rd_ptr_rst | frame_ready, 1'b0, 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check1("R1 after reset", wr_en | wr_ptr_rst | rd_ptr_rst | frame_ready, 1'b0, 0);
        // directed: single-cycle syncs, acknowledged frame
        run_frame(12, 32, 1, 1, 1'b1);
        // directed: frame cut short before the window ends, stray ack
        run_frame(6, 30, 3, 4, 1'b1);
        // directed: held-high syncs, no acknowledge, then a new field (R9)
        run_frame(11, 40, 6, 6, 1'b0);
        run_frame(9, 30, 2, 2, 1'b1);
        // constrained random frames
        for (int k = 0; k < 10; k++) begin
            run_frame(int'($urandom_range(5, 14)), int'($urandom_range(30, 45)),
                      int'($urandom_range(1, 5)), int'($urandom_range(1, 6)),
                      1'($urandom_range(0, 3) != 0));
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule